// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of an instruction into memory addresses. The two-bit mode field and the three-bit register/memory field choose how the address is built. The block adds a base register (BX or BP), an index register (SI or DI) and a displacement, which may be absent, one byte or two bytes. The result is a 16-bit effective address. The block then shifts the chosen segment register left by four bits and adds the effective address to it, giving a 20-bit physical address.

An instruction decoder presents the fields, both displacement bytes and the current register values, with a one-cycle valid strobe. One clock later the block returns:
- the effective address,
- the physical address,
- a flag that marks register mode,
- a flag that shows whether the stack segment was used,
- the number of displacement bytes the encoding consumed, so the decoder can advance past them.

Top module: `ea_gen_unit`

## Requirements
- R1: The physical address is (segment value × 16 + effective address) modulo 2^20.
- R2: Mode field 11 means register mode. The outputs are `reg_mode`=1, effective address 0, physical address 0, displacement length 0 and `used_stack`=0.
- R3: The displacement length is 0 for mode 00 (except the direct form), 1 for mode 01 and 2 for mode 10. A two-byte displacement is {`disp_hi`,`disp_lo`}.
- R4: A one-byte displacement (mode 01) is sign-extended. Bytes 00h–7Fh add 0000h–007Fh and bytes 80h–FFh add FF80h–FFFFh.
- R5: Mode 00 with register/memory field 110 is the direct form. The effective address is {`disp_hi`,`disp_lo`}, the length is 2, no register is added and the data segment is used.
- R6: The register/memory field selects the registers: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP (modes 01 and 10), 111 BX.
- R7: The forms that use BP (010, 011, and 110 outside the direct form) use the stack segment and set `used_stack`=1. Every other memory form uses the data segment with `used_stack`=0.
- R8: The effective address sum wraps modulo 2^16 before the segment is added.
- R9: The outputs register the inputs one clock after `in_valid` is high, and `out_valid` follows `in_valid` with one cycle of latency. When `in_valid` is low, all address outputs hold their values.
- R10: During reset and after it, every output is zero until the first valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode_field | input | 2 | Addressing mode field |
| rm_field | input | 3 | Register/memory field |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| bx_val | input | 16 | BX base register value |
| bp_val | input | 16 | BP base register value |
| si_val | input | 16 | SI index register value |
| di_val | input | 16 | DI index register value |
| data_seg | input | 16 | Data segment register |
| stack_seg | input | 16 | Stack segment register |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective address |
| phys_addr | output | 20 | Physical address |
| reg_mode | output | 1 | Register-mode flag |
| disp_len | output | 2 | Displacement bytes consumed (0, 1 or 2) |
| used_stack | output | 1 | Stack segment was selected |

## Verification
The assertions assume that `in_valid` and the field values are known, non-X levels at every sampled edge. They also assume that reset is held for at least one edge before the first request, so every `$past` term refers to a cycle in which reset was defined. The stimulus holds `in_valid` low through reset. After reset it drives every input only on the falling edge, so each rising edge samples settled, fully defined values. During the hold test the field and register values change while `in_valid` is low, which exposes any output that follows its inputs without the strobe.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    // Mode field encodings
    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_BYTE   = 2'b01;
    localparam logic [1:0] MODE_WORD   = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;

    // Register/memory code of the direct form when mode is 00
    localparam logic [2:0] RM_DIRECT = 3'b110;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_SI   = 2'd1,
        IDX_DI   = 2'd2
    } idx_sel_e;

    // The value equals the number of displacement bytes consumed
    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_BYTE = 2'd1,
        DISP_WORD = 2'd2
    } disp_kind_e;

    typedef struct packed {
        logic       reg_mode;
        logic       stack_seg;
        base_sel_e  base;
        idx_sel_e   idx;
        disp_kind_e disp;
    } addr_form_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_gen_pkg::*;
(
    input  logic [1:0] mode_field,
    input  logic [2:0] rm_field,
    output addr_form_t form
);

    logic is_direct;

    always_comb begin
        is_direct     = (mode_field == MODE_NODISP) && (rm_field == RM_DIRECT);
        form.reg_mode = (mode_field == MODE_REG);

        // Base and index selection from the register/memory field
        unique case (rm_field)
            3'b000:  begin form.base = BASE_BX;   form.idx = IDX_SI;   end
            3'b001:  begin form.base = BASE_BX;   form.idx = IDX_DI;   end
            3'b010:  begin form.base = BASE_BP;   form.idx = IDX_SI;   end
            3'b011:  begin form.base = BASE_BP;   form.idx = IDX_DI;   end
            3'b100:  begin form.base = BASE_NONE; form.idx = IDX_SI;   end
            3'b101:  begin form.base = BASE_NONE; form.idx = IDX_DI;   end
            3'b110:  begin form.base = BASE_BP;   form.idx = IDX_NONE; end
            default: begin form.base = BASE_BX;   form.idx = IDX_NONE; end
        endcase

        // Displacement sizing by mode
        unique case (mode_field)
            MODE_BYTE: form.disp = DISP_BYTE;
            MODE_WORD: form.disp = DISP_WORD;
            default:   form.disp = DISP_NONE;
        endcase

        // Direct form: a bare two-byte address, no registers added
        if (is_direct) begin
            form.base = BASE_NONE;
            form.disp = DISP_WORD;
        end

        if (form.reg_mode) begin
            form.base = BASE_NONE;
            form.idx  = IDX_NONE;
        end

        form.stack_seg = (form.base == BASE_BP);
    end

endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
    import ea_gen_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  base_sel_e                base_sel,
    input  idx_sel_e                 idx_sel,
    input  disp_kind_e               disp_kind,
    input  logic [OFS_W-1:0]         bx_val,
    input  logic [OFS_W-1:0]         bp_val,
    input  logic [OFS_W-1:0]         si_val,
    input  logic [OFS_W-1:0]         di_val,
    input  logic [OFS_W/2-1:0]       disp_lo,
    input  logic [OFS_W/2-1:0]       disp_hi,
    output logic [OFS_W-1:0]         eff_addr
);

    localparam int BYTE_W = OFS_W / 2;
    localparam int EXT_W  = OFS_W - BYTE_W;

    logic [OFS_W-1:0] base_term;
    logic [OFS_W-1:0] idx_term;
    logic [OFS_W-1:0] disp_term;

    always_comb begin
        unique case (base_sel)
            BASE_BX: base_term = bx_val;
            BASE_BP: base_term = bp_val;
            default: base_term = '0;
        endcase

        unique case (idx_sel)
            IDX_SI:  idx_term = si_val;
            IDX_DI:  idx_term = di_val;
            default: idx_term = '0;
        endcase

        unique case (disp_kind)
            DISP_BYTE: disp_term = {{EXT_W{disp_lo[BYTE_W-1]}}, disp_lo};
            DISP_WORD: disp_term = {disp_hi, disp_lo};
            default:   disp_term = '0;
        endcase

        // Truncation to OFS_W bits gives the modulo wrap
        eff_addr = base_term + idx_term + disp_term;
    end

endmodule

// File: rtl/ea_phys_form.sv
module ea_phys_form #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0]  seg_val,
    input  logic [OFS_W-1:0]  eff_addr,
    output logic [PHYS_W-1:0] phys_addr
);

    logic [PHYS_W-1:0] seg_base;
    logic [PHYS_W-1:0] ofs_ext;

    always_comb begin
        seg_base  = {seg_val, {SEG_SHIFT{1'b0}}};
        ofs_ext   = {{SEG_SHIFT{1'b0}}, eff_addr};
        phys_addr = seg_base + ofs_ext;
    end

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_gen_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFS_W + SEG_SHIFT,
    localparam int BYTE_W   = OFS_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode_field,
    input  logic [2:0]        rm_field,
    input  logic [BYTE_W-1:0] disp_lo,
    input  logic [BYTE_W-1:0] disp_hi,
    input  logic [OFS_W-1:0]  bx_val,
    input  logic [OFS_W-1:0]  bp_val,
    input  logic [OFS_W-1:0]  si_val,
    input  logic [OFS_W-1:0]  di_val,
    input  logic [OFS_W-1:0]  data_seg,
    input  logic [OFS_W-1:0]  stack_seg,
    output logic              out_valid,
    output logic [OFS_W-1:0]  eff_addr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              reg_mode,
    output logic [1:0]        disp_len,
    output logic              used_stack
);

    typedef struct packed {
        logic              valid;
        logic [OFS_W-1:0]  ea;
        logic [PHYS_W-1:0] pa;
        logic              reg_mode;
        logic [1:0]        disp_len;
        logic              stack;
    } result_t;

    addr_form_t        form;
    logic [OFS_W-1:0]  ea_comb;
    logic [OFS_W-1:0]  seg_pick;
    logic [PHYS_W-1:0] pa_comb;
    result_t           res_d;
    result_t           res_q;

    ea_mode_decode u_decode (
        .mode_field (mode_field),
        .rm_field   (rm_field),
        .form       (form)
    );

    ea_offset_sum #(.OFS_W(OFS_W)) u_sum (
        .base_sel  (form.base),
        .idx_sel   (form.idx),
        .disp_kind (form.disp),
        .bx_val    (bx_val),
        .bp_val    (bp_val),
        .si_val    (si_val),
        .di_val    (di_val),
        .disp_lo   (disp_lo),
        .disp_hi   (disp_hi),
        .eff_addr  (ea_comb)
    );

    assign seg_pick = form.stack_seg ? stack_seg : data_seg;

    ea_phys_form #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
        .seg_val   (seg_pick),
        .eff_addr  (ea_comb),
        .phys_addr (pa_comb)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.reg_mode = form.reg_mode;
            if (form.reg_mode) begin
                res_d.ea       = '0;
                res_d.pa       = '0;
                res_d.disp_len = 2'd0;
                res_d.stack    = 1'b0;
            end else begin
                res_d.ea       = ea_comb;
                res_d.pa       = pa_comb;
                res_d.disp_len = form.disp;
                res_d.stack    = form.stack_seg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.valid;
    assign eff_addr   = res_q.ea;
    assign phys_addr  = res_q.pa;
    assign reg_mode   = res_q.reg_mode;
    assign disp_len   = res_q.disp_len;
    assign used_stack = res_q.stack;

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ($past(in_valid) && $past(rst_n)));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
            ($stable(eff_addr) && $stable(phys_addr) && $stable(disp_len)));

    // R2
    reg_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && reg_mode) |->
            (eff_addr == '0 && phys_addr == '0 && disp_len == 2'd0 && !used_stack));

    // R3
    byte_disp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(mode_field) == MODE_BYTE) |->
            (disp_len == 2'd1));

    // R5
    direct_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(mode_field) == MODE_NODISP &&
         $past(rm_field) == RM_DIRECT) |->
            (eff_addr == {$past(disp_hi), $past(disp_lo)} && !used_stack && disp_len == 2'd2));

    // R3
    disp_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_len != 2'd3);

endmodule

// File: tb/ea_gen_unit_test.sv
`timescale 1ns/1ps
module ea_gen_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode_field = 2'b00;
    logic [2:0]  rm_field = 3'b000;
    logic [7:0]  disp_lo = 8'h00;
    logic [7:0]  disp_hi = 8'h00;
    logic [15:0] bx_val = 16'h0000;
    logic [15:0] bp_val = 16'h0000;
    logic [15:0] si_val = 16'h0000;
    logic [15:0] di_val = 16'h0000;
    logic [15:0] data_seg = 16'h0000;
    logic [15:0] stack_seg = 16'h0000;
    logic        out_valid;
    logic [15:0] eff_addr;
    logic [19:0] phys_addr;
    logic        reg_mode;
    logic [1:0]  disp_len;
    logic        used_stack;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ea_gen_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mode_field(mode_field), .rm_field(rm_field),
        .disp_lo(disp_lo), .disp_hi(disp_hi),
        .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
        .data_seg(data_seg), .stack_seg(stack_seg),
        .out_valid(out_valid), .eff_addr(eff_addr), .phys_addr(phys_addr),
        .reg_mode(reg_mode), .disp_len(disp_len), .used_stack(used_stack)
    );

    task automatic check(string tag, logic ev, logic [15:0] eea, logic [19:0] epa,
                         logic erm, logic [1:0] elen, logic estk);
        compared++;
        if (out_valid !== ev || eff_addr !== eea || phys_addr !== epa ||
            reg_mode !== erm || disp_len !== elen || used_stack !== estk) begin
            mismatched++;
            $display("FAIL %s: got v=%0b ea=%h pa=%h rm=%0b len=%0d stk=%0b, expected v=%0b ea=%h pa=%h rm=%0b len=%0d stk=%0b",
                     tag, out_valid, eff_addr, phys_addr, reg_mode, disp_len, used_stack,
                     ev, eea, epa, erm, elen, estk);
        end
    endtask

    // Independent expectation from the requirement text
    task automatic expect_model(string tag);
        logic [15:0] b, x, d, ea;
        logic [19:0] pa;
        logic stk;
        logic [1:0] len;
        if (mode_field == 2'b11) begin
            check(tag, 1'b1, 16'h0, 20'h0, 1'b1, 2'd0, 1'b0);
            return;
        end
        b = 16'h0; x = 16'h0; stk = 1'b0;
        case (rm_field)
            3'd0: begin b = bx_val; x = si_val; end
            3'd1: begin b = bx_val; x = di_val; end
            3'd2: begin b = bp_val; x = si_val; stk = 1'b1; end
            3'd3: begin b = bp_val; x = di_val; stk = 1'b1; end
            3'd4: x = si_val;
            3'd5: x = di_val;
            3'd6: begin b = bp_val; stk = 1'b1; end
            default: b = bx_val;
        endcase
        case (mode_field)
            2'b01: begin d = {{8{disp_lo[7]}}, disp_lo}; len = 2'd1; end
            2'b10: begin d = {disp_hi, disp_lo}; len = 2'd2; end
            default: begin d = 16'h0; len = 2'd0; end
        endcase
        if (mode_field == 2'b00 && rm_field == 3'd6) begin
            b = 16'h0; stk = 1'b0; d = {disp_hi, disp_lo}; len = 2'd2;
        end
        ea = b + x + d;
        pa = {(stk ? stack_seg : data_seg), 4'h0} + {4'h0, ea};
        check(tag, 1'b1, ea, pa, 1'b0, len, stk);
    endtask

    task automatic issue(logic [1:0] m, logic [2:0] r, logic [7:0] lo, logic [7:0] hi);
        @(negedge clk);
        mode_field = m; rm_field = r; disp_lo = lo; disp_hi = hi; in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_regs(logic [15:0] bx, logic [15:0] bp, logic [15:0] si,
                             logic [15:0] di, logic [15:0] ds, logic [15:0] ss);
        bx_val = bx; bp_val = bp; si_val = si; di_val = di; data_seg = ds; stack_seg = ss;
    endtask

    task automatic t_reset();
        // R10
        check("R10 reset", 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_all_forms();
        load_regs(16'h1100, 16'h2200, 16'h0030, 16'h0004, 16'h4000, 16'h5000);
        for (int m = 0; m < 3; m++) begin
            for (int r = 0; r < 8; r++) begin
                issue(m[1:0], r[2:0], 8'h21, 8'h03);
                // R6 R7 R3 R1
                expect_model($sformatf("R6/R7 mode=%0d rm=%0d", m, r));
            end
        end
        // R6 R7 explicit: BP+DI with byte disp 21 -> 2225, stack 5000 -> 52225
        issue(2'b01, 3'b011, 8'h21, 8'h00);
        check("R7 bp+di", 1'b1, 16'h2225, 20'h52225, 1'b0, 2'd1, 1'b1);
        // R6 DI alone, no disp
        issue(2'b00, 3'b101, 8'h00, 8'h00);
        check("R6 di", 1'b1, 16'h0004, 20'h40004, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_register_mode();
        issue(2'b11, 3'b010, 8'hAA, 8'hBB);
        // R2
        check("R2 register mode", 1'b1, 16'h0, 20'h0, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_sign_ext();
        load_regs(16'h0000, 16'h0000, 16'h0100, 16'h0000, 16'h1000, 16'h2000);
        issue(2'b01, 3'b100, 8'h7F, 8'h55);
        // R4 positive byte
        check("R4 disp 7F", 1'b1, 16'h017F, 20'h1017F, 1'b0, 2'd1, 1'b0);
        issue(2'b01, 3'b100, 8'h80, 8'h55);
        // R4 negative byte
        check("R4 disp 80", 1'b1, 16'h0080, 20'h10080, 1'b0, 2'd1, 1'b0);
        issue(2'b01, 3'b100, 8'hFF, 8'h00);
        check("R4 disp FF", 1'b1, 16'h00FF, 20'h100FF, 1'b0, 2'd1, 1'b0);
        issue(2'b10, 3'b100, 8'h80, 8'h00);
        // R3 word disp not sign-extended
        check("R3 word disp", 1'b1, 16'h0180, 20'h10180, 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_direct();
        load_regs(16'h0000, 16'h7777, 16'h0000, 16'h0000, 16'h2000, 16'h9000);
        issue(2'b00, 3'b110, 8'h34, 8'h12);
        // R5
        check("R5 direct", 1'b1, 16'h1234, 20'h21234, 1'b0, 2'd2, 1'b0);
        issue(2'b01, 3'b110, 8'h10, 8'h00);
        // R7 BP form with byte disp uses stack segment
        check("R7 bp+disp", 1'b1, 16'h7787, 20'h97787, 1'b0, 2'd1, 1'b1);
    endtask

    task automatic t_wrap();
        load_regs(16'hFFFF, 16'h0000, 16'h0002, 16'h0000, 16'h1000, 16'h0000);
        issue(2'b00, 3'b000, 8'h00, 8'h00);
        // R8
        check("R8 ea wrap", 1'b1, 16'h0001, 20'h10001, 1'b0, 2'd0, 1'b0);
        load_regs(16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000);
        issue(2'b00, 3'b111, 8'h00, 8'h00);
        // R1 physical wrap
        check("R1 phys wrap", 1'b1, 16'hFFFF, 20'h0FFEF, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_hold();
        load_regs(16'h0010, 16'h0000, 16'h0020, 16'h0000, 16'h0300, 16'h0000);
        issue(2'b10, 3'b000, 8'h00, 8'h01);
        // R9 captured value
        check("R9 capture", 1'b1, 16'h0130, 20'h03130, 1'b0, 2'd2, 1'b0);
        in_valid = 1'b0;
        mode_field = 2'b11; rm_field = 3'b011;
        load_regs(16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD, 16'hEEEE, 16'h1111);
        @(negedge clk);
        @(negedge clk);
        // R9 outputs hold, valid drops
        check("R9 hold", 1'b0, 16'h0130, 20'h03130, 1'b0, 2'd2, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_forms();
        t_register_mode();
        t_sign_ext();
        t_direct();
        t_wrap();
        t_hold();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule